// File: doc/BRIEF.md
# Directed Rounding Result Fixup

This block repairs a floating-point result that an arithmetic unit has already rounded to nearest or toward zero, so that the stored bit pattern matches what rounding toward plus infinity or toward minus infinity would have produced. The caller supplies three things. The first is the instruction word that produced the result. The second is the 64-bit destination register value. The third is the active 2-bit rounding mode. The block returns the corrected 64-bit value one clock later, together with a done pulse and an error flag.

The correction is a conditional increment of the raw bit pattern. Whether the increment happens depends on the sign of the value and on the rounding direction. There are three operand formats. A scalar single uses only the low word. A double uses all 64 bits, with one carry chain. A paired single holds two single lanes that are corrected independently. Whether the original result was inexact is decided outside this block, and so is the computation of that result.

Top module: `dir_round_fixup`

## Requirements
- R1: While reset is high and after it is released, `value_out`, `done_out` and `err_out` are all zero until the first accepted request.
- R2: `done_out` is high in exactly the cycle after a cycle with `valid_in` high, and low otherwise. `value_out` and `err_out` change only in those cycles.
- R3: The rounding mode is 2 bits: 0 is to nearest, 1 is toward zero, 2 is toward plus infinity and 3 is toward minus infinity. Modes 0 and 1 return the value unchanged with `err_out` low.
- R4: In mode 2, the field under correction is incremented by one when its sign bit is 0, and left alone when the sign bit is 1.
- R5: In mode 3, the field under correction is incremented by one when its sign bit is 1, and left alone when the sign bit is 0.
- R6: The format comes from instruction bits 7:5. Value 6 is scalar single, 7 is double and 4 is paired single. Any other value sets `err_out` and returns the value unchanged.
- R7: Scalar single takes its sign from bit 31 and increments only bits 31:0, wrapping from 0xFFFFFFFF to 0. Bits 63:32 pass through unchanged.
- R8: Double takes its sign from bit 63 and increments all 64 bits as one number, so a carry out of bit 31 reaches bit 32. Bit 31 has no effect on the decision.
- R9: Paired single treats bits 63:32 (sign bit 63) and bits 31:0 (sign bit 31) as separate lanes. Each lane is decided by its own sign and wraps on its own, and no carry passes between the lanes.
- R10: An instruction whose bits 31:26 are not equal to 4 sets `err_out` and returns the value unchanged.
- R11: A compare instruction sets `err_out` and returns the value unchanged. A compare instruction is one whose bits 10:0 equal 0x28C, 0x28D, 0x28E, 0x2CC, 0x2CD, 0x2CE, 0x2EC, 0x2ED or 0x2EE.
- R12: `err_out` is low for every request with major field 4, a format of 4, 6 or 7, and a function that is not a compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe; the inputs are sampled when this is high |
| insn_in | input | 32 | Instruction word that produced the result |
| value_in | input | 64 | Destination register value before correction |
| rmode_in | input | 2 | Rounding mode (0 nearest, 1 zero, 2 plus infinity, 3 minus infinity) |
| value_out | output | 64 | Corrected value, registered |
| done_out | output | 1 | One-cycle pulse marking a new result |
| err_out | output | 1 | The request was not handled; the value was passed back unchanged |

## Verification
In double format, the lane increment and the cross-word carry happen in the same cycle. In paired format, a low-lane wrap from 0xFFFFFFFF lands in the same cycle as an increment of the high lane. The bench provokes both cases on purpose: it applies all-ones low words in both formats, with signs that make both lanes, or only one, qualify for correction. A double must show the high word raised by exactly one. A pair must show the high word raised only by its own sign decision and never by the low lane's carry. A behavioural reference model computes these results with plain 64-bit and 32-bit arithmetic and is compared against the outputs every cycle, including back-to-back requests from a pseudo-random stream.

// File: rtl/rfix_pkg.sv
package rfix_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_SGL  = 2'd1,
    FMT_DBL  = 2'd2,
    FMT_PAIR = 2'd3
  } fmt_e;

  // major opcode value and format codes carried in the instruction word
  localparam logic [5:0] MAJOR_CODE = 6'd4;
  localparam logic [2:0] TY_SGL     = 3'd6;
  localparam logic [2:0] TY_DBL     = 3'd7;
  localparam logic [2:0] TY_PAIR    = 3'd4;

endpackage

// File: rtl/rfix_decode.sv
module rfix_decode
  import rfix_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output fmt_e              fmt,
  output logic              reject
);
  localparam int MAJ_LSB = INSN_W - 6;

  logic [5:0] major;
  logic [2:0] ty;
  logic       major_ok;
  logic       is_cmp;
  logic       unused_mid;

  assign major      = insn[INSN_W-1:MAJ_LSB];
  assign ty         = insn[7:5];
  assign major_ok   = (major == MAJOR_CODE);
  assign unused_mid = ^insn[MAJ_LSB-1:11];

  // compare class: function group 010, low bits 011xx except 01111
  assign is_cmp = (insn[10:8] == 3'b010) && (insn[4:2] == 3'b011) &&
                  (insn[1:0] != 2'b11);

  always_comb begin
    fmt    = FMT_NONE;
    reject = 1'b1;
    if (major_ok && !is_cmp) begin
      unique case (ty)
        TY_SGL:  begin fmt = FMT_SGL;  reject = 1'b0; end
        TY_DBL:  begin fmt = FMT_DBL;  reject = 1'b0; end
        TY_PAIR: begin fmt = FMT_PAIR; reject = 1'b0; end
        default: begin fmt = FMT_NONE; reject = 1'b1; end
      endcase
    end
  end

  always_comb begin
    if (!reject) assert (fmt != FMT_NONE); // R12
  end
endmodule

// File: rtl/rfix_steer.sv
module rfix_steer
  import rfix_pkg::*;
(
  input  fmt_e   fmt,
  input  rmode_e mode,
  input  logic   sign_lo,
  input  logic   sign_hi,
  output logic   inc_lo,
  output logic   inc_hi,
  output logic   link
);
  logic want_lo, want_hi, up, dn;

  assign up      = (mode == RM_UP);
  assign dn      = (mode == RM_DOWN);
  assign want_lo = (up && !sign_lo) || (dn && sign_lo);
  assign want_hi = (up && !sign_hi) || (dn && sign_hi);

  always_comb begin
    inc_lo = 1'b0;
    inc_hi = 1'b0;
    link   = 1'b0;
    unique case (fmt)
      FMT_SGL:  inc_lo = want_lo;
      FMT_DBL:  begin inc_lo = want_hi; link = 1'b1; end
      FMT_PAIR: begin inc_lo = want_lo; inc_hi = want_hi; end
      default:  ;
    endcase
  end

  always_comb begin
    if (link) assert (!inc_hi); // R8
  end
endmodule

// File: rtl/rfix_lane.sv
module rfix_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);
  assign {cout, y} = {1'b0, a} + {{W{1'b0}}, cin};
endmodule

// File: rtl/dir_round_fixup.sv
module dir_round_fixup
  import rfix_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int INSN_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_in,
  input  logic [INSN_W-1:0]   insn_in,
  input  logic [2*LANE_W-1:0] value_in,
  input  logic [1:0]          rmode_in,
  output logic [2*LANE_W-1:0] value_out,
  output logic                done_out,
  output logic                err_out
);
  localparam int NLANE  = 2;
  localparam int DATA_W = NLANE * LANE_W;

  fmt_e   fmt;
  logic   reject;
  logic   inc_lo, inc_hi, link;
  rmode_e mode;
  logic [NLANE-1:0]  lane_inc;
  logic [NLANE-1:0]  lane_cin;
  logic [NLANE-1:0]  lane_cout;
  logic [DATA_W-1:0] fixed;

  assign mode = rmode_e'(rmode_in);

  rfix_decode #(.INSN_W(INSN_W)) u_dec (
    .insn   (insn_in),
    .fmt    (fmt),
    .reject (reject)
  );

  rfix_steer u_steer (
    .fmt     (fmt),
    .mode    (mode),
    .sign_lo (value_in[LANE_W-1]),
    .sign_hi (value_in[DATA_W-1]),
    .inc_lo  (inc_lo),
    .inc_hi  (inc_hi),
    .link    (link)
  );

  assign lane_inc = {inc_hi, inc_lo};

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    if (gi == 0) begin : g_first
      assign lane_cin[gi] = lane_inc[gi];
    end else begin : g_rest
      assign lane_cin[gi] = link ? lane_cout[gi-1] : lane_inc[gi];
    end
    rfix_lane #(.W(LANE_W)) u_lane (
      .a    (value_in[gi*LANE_W +: LANE_W]),
      .cin  (lane_cin[gi]),
      .y    (fixed[gi*LANE_W +: LANE_W]),
      .cout (lane_cout[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value_out <= '0;
      err_out   <= 1'b0;
      done_out  <= 1'b0;
    end else begin
      done_out <= valid_in;
      if (valid_in) begin
        value_out <= reject ? value_in : fixed;
        err_out   <= reject;
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> done_out); // R2
  AST_DONE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> (!done_out && $stable(value_out) && $stable(err_out))); // R2
  AST_NEAR_ZERO_KEEP: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !rmode_in[1]) |=> (value_out == $past(value_in))); // R3
  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (done_out && err_out) |-> (value_out == $past(value_in))); // R6
  AST_SGL_UPPER: assert property (@(posedge clk) disable iff (rst)
    (valid_in && fmt == FMT_SGL) |=>
      (value_out[DATA_W-1:LANE_W] == $past(value_in[DATA_W-1:LANE_W]))); // R7
  AST_PAIR_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (valid_in && fmt == FMT_PAIR && mode == RM_DOWN && !value_in[DATA_W-1]) |=>
      (value_out[DATA_W-1:LANE_W] == $past(value_in[DATA_W-1:LANE_W]))); // R9
endmodule

// File: tb/tb_dir_round_fixup.sv
module tb_dir_round_fixup;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [31:0] insn_in = '0;
  logic [63:0] value_in = '0;
  logic [1:0]  rmode_in = '0;
  logic [63:0] value_out;
  logic        done_out, err_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  dir_round_fixup dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .insn_in(insn_in),
    .value_in(value_in), .rmode_in(rmode_in), .value_out(value_out),
    .done_out(done_out), .err_out(err_out)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [10:0] fn);
    return {op, 15'h1a2b, fn};
  endfunction

  function automatic void ref_fix(input logic [31:0] insn, input logic [63:0] v,
                                  input logic [1:0] m, output logic [63:0] o,
                                  output logic e, output string t);
    logic [10:0] fn;
    logic [31:0] lo, hi;
    logic up, dn;
    fn = insn[10:0];
    up = (m == 2'd2);
    dn = (m == 2'd3);
    o = v;
    e = 1'b1;
    lo = v[31:0];
    hi = v[63:32];
    if (insn[31:26] != 6'd4) t = "R10";
    else if (!(insn[7:5] inside {3'd4, 3'd6, 3'd7})) t = "R6";
    else if (fn inside {11'h28c, 11'h28d, 11'h28e, 11'h2cc, 11'h2cd, 11'h2ce,
                        11'h2ec, 11'h2ed, 11'h2ee}) t = "R11";
    else begin
      e = 1'b0;
      case (insn[7:5])
        3'd6: begin
          if ((up && !v[31]) || (dn && v[31])) lo = lo + 32'd1;
          o = {hi, lo};
          t = !m[1] ? "R3" : (up ? "R7/R4" : "R7/R5");
        end
        3'd7: begin
          if ((up && !v[63]) || (dn && v[63])) o = v + 64'd1;
          t = !m[1] ? "R3" : (up ? "R8/R4" : "R8/R5");
        end
        default: begin
          if ((up && !v[31]) || (dn && v[31])) lo = lo + 32'd1;
          if ((up && !v[63]) || (dn && v[63])) hi = hi + 32'd1;
          o = {hi, lo};
          t = !m[1] ? "R3" : (up ? "R9/R4" : "R9/R5");
        end
      endcase
    end
  endfunction

  // behavioural reference, advanced on every clock
  logic [63:0] m_out = '0;
  logic        m_done = 1'b0, m_err = 1'b0;
  string       m_tag = "R1";
  always @(posedge clk) begin : model
    logic [63:0] o;
    logic e;
    string t;
    if (rst) begin
      m_out <= '0; m_done <= 1'b0; m_err <= 1'b0; m_tag <= "R1";
    end else begin
      m_done <= valid_in;
      if (valid_in) begin
        ref_fix(insn_in, value_in, rmode_in, o, e, t);
        m_out <= o; m_err <= e; m_tag <= t;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (done_out !== m_done) begin
        failures++;
        $display("FAIL %s done act=%0b exp=%0b", rst ? "R1" : "R2", done_out, m_done);
      end
      checks++;
      if (err_out !== m_err) begin
        failures++;
        $display("FAIL %s err act=%0b exp=%0b", m_err ? m_tag : "R12", err_out, m_err);
      end
      checks++;
      if (value_out !== m_out) begin
        failures++;
        $display("FAIL %s value act=%h exp=%h", m_tag, value_out, m_out);
      end
    end
  end

  task automatic send(input logic [31:0] insn, input logic [63:0] v, input logic [1:0] m);
    @(posedge clk); #(PERIOD/4);
    valid_in = 1'b1; insn_in = insn; value_in = v; rmode_in = m;
  endtask

  task automatic idle();
    @(posedge clk); #(PERIOD/4);
    valid_in = 1'b0;
  endtask

  localparam logic [10:0] F_SGL  = 11'h2c0;
  localparam logic [10:0] F_DBL  = 11'h2e0;
  localparam logic [10:0] F_PAIR = 11'h280;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    lfsr = 32'hace1_2468;
    repeat (3) @(posedge clk);
    #(PERIOD/4) rst = 1'b0;   // R1 checked while held and right after
    idle(); idle();
    // R7 with R4 / R5: scalar single, upper word passes
    send(mk(6'd4, F_SGL), 64'hdead_beef_3f80_0000, 2'd2);
    send(mk(6'd4, F_SGL), 64'hdead_beef_bf80_0000, 2'd2);
    send(mk(6'd4, F_SGL), 64'h0000_0001_8000_0000, 2'd3);
    send(mk(6'd4, F_SGL), 64'h1234_5678_ffff_ffff, 2'd3);
    send(mk(6'd4, F_SGL), 64'h1234_5678_7fff_ffff, 2'd2);
    // R8: carry crosses the words; bit 31 ignored
    send(mk(6'd4, F_DBL), 64'h3ff0_0000_ffff_ffff, 2'd2);
    send(mk(6'd4, F_DBL), 64'hbff0_0000_ffff_ffff, 2'd3);
    send(mk(6'd4, F_DBL), 64'h3ff0_0000_8000_0000, 2'd3);
    send(mk(6'd4, F_DBL), 64'hffff_ffff_ffff_ffff, 2'd3);
    // R9: independent lanes, no inter-lane carry
    send(mk(6'd4, F_PAIR), 64'h7fff_ffff_7fff_ffff, 2'd2);
    send(mk(6'd4, F_PAIR), 64'h8000_0000_ffff_ffff, 2'd3);
    send(mk(6'd4, F_PAIR), 64'h0000_0005_ffff_ffff, 2'd3);
    send(mk(6'd4, F_PAIR), 64'h8000_0000_0000_0001, 2'd2);
    idle();
    // R3: nearest / zero untouched
    send(mk(6'd4, F_DBL), 64'h3ff0_0000_ffff_ffff, 2'd0);
    send(mk(6'd4, F_PAIR), 64'h8000_0000_ffff_ffff, 2'd1);
    // R6, R10, R11: rejected, value unchanged
    send(mk(6'd4, 11'h2a0), 64'h0000_0000_0000_0010, 2'd2);
    send(mk(6'd5, F_SGL), 64'h0000_0000_0000_0010, 2'd2);
    send(mk(6'd4, 11'h2cc), 64'h0000_0000_0000_0010, 2'd2);
    send(mk(6'd4, 11'h2ee), 64'h8000_0000_0000_0010, 2'd3);
    send(mk(6'd4, 11'h28d), 64'h0000_0000_0000_0010, 2'd2);
    send(mk(6'd4, 11'h2cf), 64'h0000_0000_0000_0010, 2'd2);
    idle(); idle();
    // pseudo-random stream with back-to-back requests
    for (int i = 0; i < 400; i++) begin
      logic [10:0] fn;
      logic [63:0] v;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:2])
        2'd0: fn = F_SGL;
        2'd1: fn = F_DBL;
        2'd2: fn = F_PAIR;
        default: fn = {3'b010, lfsr[9:7], lfsr[14:10]};
      endcase
      v = {lfsr[4] ? 32'hffff_ffff : {lfsr[5], lfsr[30:0]},
           lfsr[6] ? 32'hffff_ffff : {lfsr[11], lfsr[31:1]}};
      if (lfsr[17:16] == 2'd0) idle();
      else send(mk(lfsr[20] && lfsr[21] ? 6'd3 : 6'd4, fn), v, lfsr[13:12]);
    end
    idle(); idle(); idle();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule